// File: doc/BRIEF.md
# Primary-Side Digital PLL Synchronizer with Startup Sequencing

This block sits on the primary side of an isolated bridge converter. It runs on the fast clock of an external ring oscillator whose supply voltage is set by a DAC. A free-running divider turns that fast clock into a local sync clock. A comparator watches the sensed transformer voltage and toggles its output in step with the remote bridge. The block measures where each rising comparator edge falls relative to the divider wrap and filters that error into a supply code, so that the oscillator settles at 2^DIV_BITS times the switching frequency with the sync clock aligned to the reference.

Startup is sequenced. After reset the phase loop stays idle and the supply code is held at mid-scale until a set number of comparator transitions have been seen. The loop then acquires. Lock is declared after a run of small phase errors. Only then is the primary bridge gate drive released. A frequency step at the reference is an expected event. It drives the error up, drops lock and withdraws the gate enable until the loop settles again.

Top module: `dpll_sync_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it, sync_clk, phase_err, pll_en, lock_ok and gate_en are 0 and dac_code is mid-scale (2^(DAC_BITS-1), 512 by default).
- R2: sync_clk is the top bit of a DIV_BITS-wide free-running counter of fast clocks. Its falling edges, which mark the divider wrap, are exactly 2^DIV_BITS (512) cycles apart.
- R3: pll_en rises once START_EDGES (4) comparator transitions of either direction have been seen after reset, and then stays high until reset. Before that, phase_err stays 0 and dac_code stays at mid-scale.
- R4: A rising comparator edge first presented while the divider count is K gives phase_err = K for K < 2^(DIV_BITS-1) and K - 2^DIV_BITS otherwise (two's complement, DIV_BITS wide). The two-flop synchronizer delay is compensated.
- R5: Each phase sample updates an integrator as I := clamp(I - err*2^KI_SHIFT). The integrator starts at mid-scale, and with the default KI_SHIFT = 0 the step is err itself.
- R6: After each sample, dac_code = clamp(I - err*2^KP_SHIFT), using the updated integrator. With the default KP_SHIFT = 2 this is I - 4*err. A positive error lowers the code.
- R7: Both the integrator and dac_code saturate at 0 and at 2^DAC_BITS-1 (1023), never wrapping.
- R8: lock_ok rises after LOCK_RUN (8) consecutive samples with |phase_err| <= LOCK_TOL (4). A sample outside the tolerance restarts the run.
- R9: While locked, lock_ok falls after UNLOCK_RUN (2) consecutive samples outside the tolerance. A single outlier followed by an in-tolerance sample leaves it high.
- R10: gate_en rises one fast cycle after lock_ok rises, falls in the same cycle as lock_ok, and is never high while lock_ok is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock from the supply-modulated ring oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| comp_in | input | 1 | Asynchronous comparator output following the reference bridge |
| sync_clk | output | 1 | Divided local clock, top bit of the divider |
| phase_err | output | DIV_BITS | Signed phase error of the latest reference edge, in fast cycles |
| dac_code | output | DAC_BITS | Supply code for the oscillator DAC |
| pll_en | output | 1 | Phase loop enabled after the startup edge count |
| lock_ok | output | 1 | Lock declared |
| gate_en | output | 1 | Release of the primary bridge gate drive |

## Verification
A comparator rising edge first presented while the divider count is K reaches phase_err three fast cycles later: two synchronizer stages plus the sample register. dac_code and lock_ok follow one cycle after that, and gate_en one cycle later still on a rise. The bench therefore drives comp_in on a falling clock edge at a divider count it knows from the observed sync_clk fall. It reads phase_err, dac_code and lock_ok at the falling edge after the fourth rising edge, and reads gate_en again one cycle later. pll_en is read several cycles after the qualifying transition, and the divider period is taken between two sync_clk falls.

// File: rtl/dpll_pkg.sv
// Package: shared types for the primary-side PLL synchronizer.
// Assumes: nothing beyond the sequencer state encoding below.
package dpll_pkg;

    // Startup and lock sequencer states.
    typedef enum logic [1:0] {
        SEQ_WAIT = 2'd0,   // counting comparator transitions, loop idle
        SEQ_ACQ  = 2'd1,   // loop running, looking for a lock run
        SEQ_LOCK = 2'd2    // lock declared
    } seq_state_t;

endpackage

// File: rtl/dpll_edge_sync.sv
// Module: brings the asynchronous comparator output into the fast clock
// domain through STAGES flops and flags its rising and falling edges.
// Assumes: comp_in pulses are far longer than STAGES fast cycles.
module dpll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    // Edge flags, valid for one cycle.
    always_comb begin
        rise = sync_q[STAGES-1] & ~last_q;
        fall = ~sync_q[STAGES-1] & last_q;
    end

endmodule

// File: rtl/dpll_phase_det.sv
// Module: divider producing the sync clock, plus a phase detector that
// samples the divider count at each synchronized reference rising edge.
// Assumes: ref_rise lags the raw edge by exactly LAT cycles; that lag is
// subtracted so the error refers to the raw edge.
module dpll_phase_det #(
    parameter int DIV_BITS = 9,
    parameter int LAT      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       ref_rise,
    output logic                       sync_clk,
    output logic signed [DIV_BITS-1:0] phase_err,
    output logic                       sample_vld
);

    localparam logic [DIV_BITS-1:0] LAT_W = DIV_BITS'(LAT);

    logic [DIV_BITS-1:0] div_q;

    // Free-running divider of the fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Sample the signed distance to the nearest wrap on each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_err  <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= enable & ref_rise;
            if (enable && ref_rise) phase_err <= $signed(div_q - LAT_W);
        end
    end

    assign sync_clk = div_q[DIV_BITS-1];

endmodule

// File: rtl/dpll_loop_filter.sv
// Module: proportional-integral loop filter with shift gains and a
// saturating integrator, producing the oscillator supply code.
// Assumes: a positive phase error means the local clock is early and the
// oscillator must slow down, so the code is lowered.
module dpll_loop_filter #(
    parameter int DIV_BITS = 9,
    parameter int DAC_BITS = 10,
    parameter int KP_SHIFT = 2,
    parameter int KI_SHIFT = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_vld,
    input  logic signed [DIV_BITS-1:0] phase_err,
    output logic [DAC_BITS-1:0]        dac_code
);

    localparam int SH_MAX = (KP_SHIFT > KI_SHIFT) ? KP_SHIFT : KI_SHIFT;
    localparam int WIDE   = (((DIV_BITS + SH_MAX) > DAC_BITS) ? (DIV_BITS + SH_MAX) : DAC_BITS) + 2;
    localparam logic signed [WIDE-1:0] CODE_TOP = {{(WIDE-DAC_BITS){1'b0}}, {DAC_BITS{1'b1}}};
    localparam logic [DAC_BITS-1:0]    CODE_MID = {1'b1, {(DAC_BITS-1){1'b0}}};

    logic [DAC_BITS-1:0]    integ_q;
    logic [DAC_BITS-1:0]    integ_nxt;
    logic [DAC_BITS-1:0]    code_nxt;
    logic signed [WIDE-1:0] err_w;
    logic signed [WIDE-1:0] integ_sum;
    logic signed [WIDE-1:0] code_sum;

    // Limit a wide signed value to the DAC code range.
    function automatic logic [DAC_BITS-1:0] clamp_code(input logic signed [WIDE-1:0] v);
        if (v < 0)             return '0;
        else if (v > CODE_TOP) return '1;
        else                   return v[DAC_BITS-1:0];
    endfunction

    // Integral then proportional path, each clamped.
    always_comb begin
        err_w     = {{(WIDE-DIV_BITS){phase_err[DIV_BITS-1]}}, phase_err};
        integ_sum = $signed({{(WIDE-DAC_BITS){1'b0}}, integ_q}) - (err_w <<< KI_SHIFT);
        integ_nxt = clamp_code(integ_sum);
        code_sum  = $signed({{(WIDE-DAC_BITS){1'b0}}, integ_nxt}) - (err_w <<< KP_SHIFT);
        code_nxt  = clamp_code(code_sum);
    end

    // Register integrator and output code once per phase sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q  <= CODE_MID;
            dac_code <= CODE_MID;
        end else if (sample_vld) begin
            integ_q  <= integ_nxt;
            dac_code <= code_nxt;
        end
    end

endmodule

// File: rtl/dpll_lock_seq.sv
// Module: startup and lock sequencer. It counts comparator transitions
// before enabling the loop, declares and drops lock from runs of phase
// samples, and releases the gate drive one cycle after lock.
// Assumes: sample_vld pulses only while pll_en is high.
module dpll_lock_seq #(
    parameter int DIV_BITS    = 9,
    parameter int START_EDGES = 4,
    parameter int LOCK_TOL    = 4,
    parameter int LOCK_RUN    = 8,
    parameter int UNLOCK_RUN  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_rise,
    input  logic                       ref_fall,
    input  logic                       sample_vld,
    input  logic signed [DIV_BITS-1:0] phase_err,
    output logic                       pll_en,
    output logic                       lock_ok,
    output logic                       gate_en
);
    import dpll_pkg::*;

    localparam int EW = $clog2(START_EDGES + 1);
    localparam int GW = $clog2(LOCK_RUN + 1);
    localparam int BW = $clog2(UNLOCK_RUN + 1);
    localparam logic [EW-1:0]       EDGE_LAST = EW'(START_EDGES - 1);
    localparam logic [GW-1:0]       GOOD_LAST = GW'(LOCK_RUN - 1);
    localparam logic [BW-1:0]       BAD_LAST  = BW'(UNLOCK_RUN - 1);
    localparam logic [DIV_BITS-1:0] TOL_W     = DIV_BITS'(LOCK_TOL);

    seq_state_t          state_q;
    logic [EW-1:0]       edge_q;
    logic [GW-1:0]       good_q;
    logic [BW-1:0]       bad_q;
    logic [DIV_BITS-1:0] err_mag;
    logic                in_tol;
    logic                lose_evt;

    // Magnitude of the error and the tolerance test.
    always_comb begin
        err_mag  = phase_err[DIV_BITS-1] ? (~phase_err + 1'b1) : phase_err;
        in_tol   = (err_mag <= TOL_W);
        lose_evt = (state_q == SEQ_LOCK) && sample_vld && !in_tol && (bad_q == BAD_LAST);
    end

    // Sequencer: transition count, lock run and unlock run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT;
            edge_q  <= '0;
            good_q  <= '0;
            bad_q   <= '0;
        end else begin
            case (state_q)
                SEQ_WAIT: begin
                    if (ref_rise || ref_fall) begin
                        edge_q <= edge_q + 1'b1;
                        if (edge_q == EDGE_LAST) state_q <= SEQ_ACQ;
                    end
                end
                SEQ_ACQ: begin
                    if (sample_vld) begin
                        if (!in_tol) begin
                            good_q <= '0;
                        end else if (good_q == GOOD_LAST) begin
                            good_q  <= '0;
                            bad_q   <= '0;
                            state_q <= SEQ_LOCK;
                        end else begin
                            good_q <= good_q + 1'b1;
                        end
                    end
                end
                SEQ_LOCK: begin
                    if (sample_vld) begin
                        if (in_tol) begin
                            bad_q <= '0;
                        end else if (bad_q == BAD_LAST) begin
                            bad_q   <= '0;
                            good_q  <= '0;
                            state_q <= SEQ_ACQ;
                        end else begin
                            bad_q <= bad_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_WAIT;
            endcase
        end
    end

    // Gate enable: set a cycle after lock, cleared with the unlock.
    always_ff @(posedge clk) begin
        if (!rst_n)                      gate_en <= 1'b0;
        else if (lose_evt)               gate_en <= 1'b0;
        else if (state_q == SEQ_LOCK)    gate_en <= 1'b1;
    end

    assign pll_en  = (state_q != SEQ_WAIT);
    assign lock_ok = (state_q == SEQ_LOCK);

endmodule

// File: rtl/dpll_sync_ctrl.sv
// Module: top of the primary-side PLL synchronizer. It ties together the
// comparator synchronizer, divider and phase detector, loop filter and
// startup/lock sequencer.
// Assumes: clk_fast is the oscillator being steered; reset is synchronous
// to it.
module dpll_sync_ctrl #(
    parameter int DIV_BITS    = 9,
    parameter int DAC_BITS    = 10,
    parameter int SYNC_STAGES = 2,
    parameter int START_EDGES = 4,
    parameter int LOCK_TOL    = 4,
    parameter int LOCK_RUN    = 8,
    parameter int UNLOCK_RUN  = 2,
    parameter int KP_SHIFT    = 2,
    parameter int KI_SHIFT    = 0
) (
    input  logic                       clk_fast,
    input  logic                       rst_n,
    input  logic                       comp_in,
    output logic                       sync_clk,
    output logic signed [DIV_BITS-1:0] phase_err,
    output logic [DAC_BITS-1:0]        dac_code,
    output logic                       pll_en,
    output logic                       lock_ok,
    output logic                       gate_en
);

    logic ref_rise;
    logic ref_fall;
    logic sample_vld;

    dpll_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_edge (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .async_in (comp_in),
        .rise     (ref_rise),
        .fall     (ref_fall)
    );

    dpll_phase_det #(
        .DIV_BITS (DIV_BITS),
        .LAT      (SYNC_STAGES)
    ) i_pd (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .enable     (pll_en),
        .ref_rise   (ref_rise),
        .sync_clk   (sync_clk),
        .phase_err  (phase_err),
        .sample_vld (sample_vld)
    );

    dpll_loop_filter #(
        .DIV_BITS (DIV_BITS),
        .DAC_BITS (DAC_BITS),
        .KP_SHIFT (KP_SHIFT),
        .KI_SHIFT (KI_SHIFT)
    ) i_lf (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .phase_err  (phase_err),
        .dac_code   (dac_code)
    );

    dpll_lock_seq #(
        .DIV_BITS    (DIV_BITS),
        .START_EDGES (START_EDGES),
        .LOCK_TOL    (LOCK_TOL),
        .LOCK_RUN    (LOCK_RUN),
        .UNLOCK_RUN  (UNLOCK_RUN)
    ) i_seq (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .ref_rise   (ref_rise),
        .ref_fall   (ref_fall),
        .sample_vld (sample_vld),
        .phase_err  (phase_err),
        .pll_en     (pll_en),
        .lock_ok    (lock_ok),
        .gate_en    (gate_en)
    );

endmodule

// File: rtl/dpll_sync_ctrl_chk.sv
// Module: property checker bound into the synchronizer top. It observes
// ports plus the internal phase-sample strobe.
// Assumes: reset is held for at least one clock before release.
module dpll_sync_ctrl_chk #(
    parameter int DIV_BITS = 9,
    parameter int DAC_BITS = 10
) (
    input logic                       clk_fast,
    input logic                       rst_n,
    input logic signed [DIV_BITS-1:0] phase_err,
    input logic [DAC_BITS-1:0]        dac_code,
    input logic                       pll_en,
    input logic                       lock_ok,
    input logic                       gate_en,
    input logic                       sample_vld
);

    localparam logic [DAC_BITS-1:0] MID = {1'b1, {(DAC_BITS-1){1'b0}}};

    // R3: the loop stays enabled once started.
    p_pll_en_hold_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        pll_en |=> pll_en);

    // R3: the supply code rests at mid-scale while the loop is idle.
    p_code_idle_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !pll_en |-> dac_code == MID);

    // R4: the phase result only moves with a sample strobe.
    p_err_on_sample_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(phase_err) |-> sample_vld);

    // R5: the code only moves in the cycle after a sample.
    p_code_after_sample_r5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(sample_vld));

    // R8: lock only while the loop runs.
    p_lock_needs_en_r8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        lock_ok |-> pll_en);

    // R8: lock is declared on a sample.
    p_lock_after_sample_r8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(lock_ok) |-> $past(sample_vld));

    // R9: lock is dropped on a sample.
    p_unlock_after_sample_r9: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $fell(lock_ok) |-> $past(sample_vld));

    // R10: the gate drive never runs without lock.
    p_gate_needs_lock_r10: assert property (@(posedge clk_fast) disable iff (!rst_n)
        gate_en |-> lock_ok);

    // R10: the gate drive rises only after lock was already held.
    p_gate_rise_r10: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(gate_en) |-> $past(lock_ok));

endmodule

bind dpll_sync_ctrl dpll_sync_ctrl_chk #(
    .DIV_BITS (DIV_BITS),
    .DAC_BITS (DAC_BITS)
) i_chk (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .phase_err  (phase_err),
    .dac_code   (dac_code),
    .pll_en     (pll_en),
    .lock_ok    (lock_ok),
    .gate_en    (gate_en),
    .sample_vld (sample_vld)
);

// File: tb/test_dpll_sync_ctrl.sv
// Bench: drives comparator edges at known divider counts and checks the
// phase result, supply code, lock and gate enable against a model.
module test_dpll_sync_ctrl;

    localparam int DIV_BITS = 9;
    localparam int DAC_BITS = 10;
    localparam int MODV     = 1 << DIV_BITS;
    localparam int HALF     = MODV / 2;
    localparam int MID      = 1 << (DAC_BITS - 1);
    localparam int TOP      = (1 << DAC_BITS) - 1;
    localparam int TOL      = 4;
    localparam int LRUN     = 8;
    localparam int URUN     = 2;
    localparam int KP       = 2;
    localparam int KI       = 0;
    localparam int NV       = 33;

    // Stimulus: divider count at which the reference edge lands.
    localparam int VK [NV] = '{5, -3, 4, -4, 7,
                               0, 1, -1, 2, -2, 3, 0, 1,
                               100, 0, 100, -100,
                               200, 200, 200,
                               -255, -255, -255, 256, -255,
                               0, 0, 0, 0, 0, 0, 0, 0};
    // Expected phase result for each entry.
    localparam int VE [NV] = '{5, -3, 4, -4, 7,
                               0, 1, -1, 2, -2, 3, 0, 1,
                               100, 0, 100, -100,
                               200, 200, 200,
                               -255, -255, -255, -256, -255,
                               0, 0, 0, 0, 0, 0, 0, 0};

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       comp = 1'b0;
    logic                       sync_clk;
    logic signed [DIV_BITS-1:0] phase_err;
    logic [DAC_BITS-1:0]        dac_code;
    logic                       pll_en;
    logic                       lock_ok;
    logic                       gate_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int m_integ  = MID;
    int m_code   = MID;
    bit m_lock   = 1'b0;
    int m_good   = 0;
    int m_bad    = 0;

    dpll_sync_ctrl i_dpll_sync_ctrl (
        .clk_fast  (clk),
        .rst_n     (rst_n),
        .comp_in   (comp),
        .sync_clk  (sync_clk),
        .phase_err (phase_err),
        .dac_code  (dac_code),
        .pll_en    (pll_en),
        .lock_ok   (lock_ok),
        .gate_en   (gate_en)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v < 0)   return 0;
        if (v > TOP) return TOP;
        return v;
    endfunction

    // Raise the comparator while the divider count equals k (mod 2^DIV_BITS).
    task automatic rise_at(input int k);
        int n;
        n = (k < 0) ? k + MODV : k;
        @(negedge sync_clk);
        repeat (n) @(posedge clk);
        @(negedge clk);
        comp = 1'b1;
    endtask

    task automatic fall_late();
        repeat (HALF) @(negedge clk);
        comp = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0;
        int t1;
        int err;
        int iraw;
        int craw;
        bit was_lock;
        bit in_tol;

        // R1: reset state.
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1", "sync_clk", int'(sync_clk), 0);
        check("R1", "phase_err", int'(phase_err), 0);
        check("R1", "dac_code", int'(dac_code), MID);
        check("R1", "pll_en", int'(pll_en), 0);
        check("R1", "lock_ok", int'(lock_ok), 0);
        check("R1", "gate_en", int'(gate_en), 0);
        rst_n = 1'b1;

        // R2: divider period between wraps.
        @(negedge sync_clk);
        t0 = cyc;
        @(negedge sync_clk);
        t1 = cyc;
        check("R2", "sync_clk period", t1 - t0, MODV);

        // R3: three transitions leave the loop idle, the fourth starts it.
        rise_at(0);
        fall_late();
        rise_at(0);
        repeat (8) @(negedge clk);
        check("R3", "pll_en after 3 transitions", int'(pll_en), 0);
        check("R3", "phase_err while idle", int'(phase_err), 0);
        check("R3", "dac_code while idle", int'(dac_code), MID);
        fall_late();
        repeat (8) @(negedge clk);
        check("R3", "pll_en after 4 transitions", int'(pll_en), 1);
        check("R3", "phase_err before first sample", int'(phase_err), 0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            rise_at(VK[i]);
            repeat (4) @(posedge clk);
            @(negedge clk);
            err      = VE[i];
            iraw     = m_integ - (err <<< KI);
            m_integ  = clampv(iraw);
            craw     = m_integ - (err <<< KP);
            m_code   = clampv(craw);
            was_lock = m_lock;
            in_tol   = (err <= TOL) && (err >= -TOL);
            if (!m_lock) begin
                if (in_tol) begin
                    m_good++;
                    if (m_good == LRUN) begin
                        m_lock = 1'b1; m_good = 0; m_bad = 0;
                    end
                end else begin
                    m_good = 0;
                end
            end else begin
                if (!in_tol) begin
                    m_bad++;
                    if (m_bad == URUN) begin
                        m_lock = 1'b0; m_bad = 0; m_good = 0;
                    end
                end else begin
                    m_bad = 0;
                end
            end
            check("R4", $sformatf("phase_err vec %0d", i), int'(phase_err), err);
            if (iraw != m_integ || craw != m_code)
                check("R7", $sformatf("clamped dac_code vec %0d", i), int'(dac_code), m_code);
            else if (err == 0)
                check("R5", $sformatf("integrator dac_code vec %0d", i), int'(dac_code), m_code);
            else
                check("R6", $sformatf("PI dac_code vec %0d", i), int'(dac_code), m_code);
            if (was_lock)
                check("R9", $sformatf("lock_ok vec %0d", i), int'(lock_ok), int'(m_lock));
            else
                check("R8", $sformatf("lock_ok vec %0d", i), int'(lock_ok), int'(m_lock));
            check("R10", $sformatf("gate_en same cycle vec %0d", i), int'(gate_en), int'(was_lock && m_lock));
            @(posedge clk);
            @(negedge clk);
            check("R10", $sformatf("gate_en next cycle vec %0d", i), int'(gate_en), int'(m_lock));
            fall_late();
        end

        // R1: reset while locked clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "lock_ok after reset", int'(lock_ok), 0);
        check("R1", "gate_en after reset", int'(gate_en), 0);
        check("R1", "pll_en after reset", int'(pll_en), 0);
        check("R1", "dac_code after reset", int'(dac_code), MID);
        check("R1", "phase_err after reset", int'(phase_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule